// File: doc/BRIEF.md
# Serial Shift Front-End with Selectable Output Phase

This block is the serial receive and pass-through stage of a cascadable eight-channel DAC controller. It oversamples an incoming serial clock, a serial data line and an active-low select using a fast system clock. While the select is low it shifts data, most significant bit first, into a 16-bit register on each serial-clock rising edge. The bit that leaves the far end of the register is driven on a serial output. Several devices can therefore be chained, with the output of one device feeding the data input of the next.

The serial output can be set to switch on the falling or on the rising serial-clock edge. The falling-edge setting is the reset default. It gives a lag of 16.5 serial-clock periods, which fits SPI mode 0 (CPOL=0, CPHA=0). The rising-edge setting gives a lag of exactly 16 periods. When the select rises, the block presents the captured word together with a single-cycle valid strobe. A downstream decoder interprets the word. In each frame the first two bits shifted in are padding that the decoder ignores.

The word output is a valid-only stream and has no ready input, so it offers no back-pressure. `word_valid` is high for exactly one system-clock cycle per frame. `word` holds its value until the next frame ends, so a consumer may read it at any time before then. The system clock must run at least four times faster than the serial clock. The serial clock idles low. The select must stay high for at least four system-clock cycles between frames.

Top module: `ser_front`

## Requirements
- R1: After reset, `dout` is 0, `word` is 0, `word_valid` is 0 and the output phase is falling-edge mode (`phase_sel` value 0).
- R2: While `cs_n` is low, every `sclk` rising edge shifts `din` into bit 0 of the 16-bit register, and the older bits move toward bit 15. The word presented at the end of a frame is the last 16 bits shifted in, in the order `word[15-i]` = the bit taken `15-i` edges before the last one. This holds across frame boundaries when a frame has fewer than 16 bits.
- R3: Each rising edge of `cs_n` produces exactly one `word_valid` pulse that lasts one system-clock cycle. `word` changes only in the cycle in which `word_valid` is high.
- R4: In falling-edge mode (phase value 0), `dout` changes only on `sclk` falling edges. After the falling edge that follows rising edge n, `dout` carries the bit taken at rising edge n-16, which is a lag of 16.5 periods.
- R5: In rising-edge mode (phase value 1), `dout` changes on `sclk` rising edges. After rising edge n, `dout` carries the bit taken at rising edge n-16, which is a lag of 16 periods.
- R6: The phase is latched from `phase_sel` only in a cycle where `phase_load` is 1. At all other times, changes on `phase_sel` have no effect on `dout` timing.
- R7: `sclk` edges that occur while `cs_n` is high neither shift the register nor change `dout`.
- R8: `dout` always drives a level, and it holds that level whenever `sclk` is idle or `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data input |
| cs_n | input | 1 | Active-low frame select |
| phase_sel | input | 1 | Output phase value: 0 selects the falling edge, 1 selects the rising edge |
| phase_load | input | 1 | Latches `phase_sel` when high |
| dout | output | 1 | Serial pass-through output |
| word | output | 16 | Word captured at the end of a frame |
| word_valid | output | 1 | One-cycle strobe for `word` |

## Verification
On every cycle, the bound checker confirms that the valid strobe never lasts longer than one cycle and comes only while the select is high. It also confirms that the word never changes outside that strobe, and that `dout` stays still once the select has been high for a few cycles or the serial clock has been quiet for a few cycles. The exact lag in each phase mode, the bit order and contents of the captured word, the rejection of clock edges while deselected, and the rule that `phase_sel` counts only with a load can be shown only by the bench's frames. The bench compares each of these against its own history of the bits it has sent.

// File: rtl/ser_front_pkg.sv
package ser_front_pkg;
  typedef enum logic {
    PH_FALL = 1'b0,
    PH_RISE = 1'b1
  } phase_e;

  localparam int unsigned WORD_W_DEF  = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/ser_front_sync.sv
module ser_front_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/ser_front_edge.sv
module ser_front_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/ser_front_shift.sv
module ser_front_shift
  import ser_front_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              fall_en,
  input  logic              sdin,
  input  phase_e            phase,
  output logic              sdout,
  output logic [WORD_W-1:0] par
);
  localparam int unsigned TOP = WORD_W - 1;

  logic [WORD_W-1:0] sreg_q;
  logic              spill_q;
  logic              dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      spill_q <= 1'b0;
      dout_q  <= 1'b0;
    end else if (shift_en) begin
      sreg_q  <= {sreg_q[TOP-1:0], sdin};
      spill_q <= sreg_q[TOP];
      if (phase == PH_RISE) dout_q <= sreg_q[TOP];
    end else if (fall_en && phase == PH_FALL) begin
      dout_q <= spill_q;
    end
  end

  assign sdout = dout_q;
  assign par   = sreg_q;
endmodule

// File: rtl/ser_front.sv
module ser_front
  import ser_front_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              cs_n,
  input  logic              phase_sel,
  input  logic              phase_load,
  output logic              dout,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  logic s_sclk, s_din, s_cs_n;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall_unused;
  logic sclk_unused_hi;
  logic active;
  phase_e phase_q;
  logic [WORD_W-1:0] par;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  ser_front_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({cs_n, din, sclk}),
    .sync_out ({s_cs_n, s_din, s_sclk})
  );

  ser_front_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (s_sclk),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  ser_front_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (s_cs_n),
    .rise  (cs_rise),
    .fall  (cs_fall_unused)
  );

  assign active         = ~s_cs_n;
  assign sclk_unused_hi = cs_fall_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase_q <= PH_FALL;
    else if (phase_load) phase_q <= phase_e'(phase_sel);
  end

  ser_front_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise & active),
    .fall_en  (sclk_fall & active),
    .sdin     (s_din),
    .phase    (phase_q),
    .sdout    (dout),
    .par      (par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cs_rise;
      if (cs_rise) word_q <= par;
    end
  end

  assign word       = word_q;
  assign word_valid = valid_q;
endmodule

// File: rtl/ser_front_chk.sv
module ser_front_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              cs_n,
  input logic              dout,
  input logic [WORD_W-1:0] word,
  input logic              word_valid
);
  localparam int unsigned QUIET = 5;

  logic [2:0] cs_hi_cnt;
  logic [2:0] sclk_same_cnt;
  logic       sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_cnt     <= '0;
      sclk_same_cnt <= '0;
      sclk_prev     <= 1'b0;
    end else begin
      sclk_prev <= sclk;
      if (!cs_n)                  cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 3'd1;
      if (sclk != sclk_prev)          sclk_same_cnt <= '0;
      else if (sclk_same_cnt != 3'd7) sclk_same_cnt <= sclk_same_cnt + 3'd1;
    end
  end

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_word_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word));

  p_valid_when_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> cs_n);

  p_dout_hold_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_cnt >= QUIET) |-> $stable(dout));

  p_dout_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_same_cnt >= QUIET) |-> $stable(dout));

  p_dout_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(dout));
endmodule

bind ser_front ser_front_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .dout       (dout),
  .word       (word),
  .word_valid (word_valid)
);

// File: tb/ser_front_test.sv
`timescale 1ns/1ps
module ser_front_test;
  localparam int W = 16;
  localparam int HALF = 10;
  localparam int MAXB = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, din = 1'b0, cs_n = 1'b1;
  logic phase_sel = 1'b0, phase_load = 1'b0;
  logic dout;
  logic [W-1:0] word;
  logic word_valid;

  int checks = 0, errors = 0;
  int n = 0;
  int vcount = 0;
  logic bits [MAXB];
  logic bmode = 1'b0;

  always #2 clk = ~clk;

  ser_front uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .cs_n(cs_n),
    .phase_sel(phase_sel), .phase_load(phase_load),
    .dout(dout), .word(word), .word_valid(word_valid)
  );

  always @(posedge clk) if (rst_n && word_valid) vcount++;

  function automatic logic bit_at(int idx);
    return (idx < 1) ? 1'b0 : bits[idx];
  endfunction

  function automatic logic [W-1:0] exp_word();
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = bit_at(n - i);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input string tag);
    logic e;
    din = b;
    wait_clk(2);
    sclk = 1'b1;
    n++;
    bits[n] = b;
    wait_clk(HALF - 2);
    e = bmode ? bit_at(n - 16) : bit_at(n - 17);
    chk(dout === e, (tag != "") ? tag : (bmode ? "R5 rise" : "R4 rise"),
        {15'd0, dout}, {15'd0, e});
    sclk = 1'b0;
    wait_clk(HALF);
    e = bit_at(n - 16);
    chk(dout === e, (tag != "") ? tag : (bmode ? "R5 fall" : "R4 fall"),
        {15'd0, dout}, {15'd0, e});
  endtask

  task automatic frame(input int len, input logic [31:0] pat, input string tag);
    int v0;
    logic dhold;
    logic [W-1:0] ew;
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = len - 1; i >= 0; i--) shift_bit(pat[i % 32], tag);
    wait_clk(4);
    dhold = dout;
    v0 = vcount;
    cs_n = 1'b1;
    wait_clk(8);
    ew = exp_word();
    chk(vcount == v0 + 1, "R3 one strobe", W'(vcount - v0), 16'd1);
    chk(word === ew, "R2 word", word, ew);
    chk(dout === dhold, "R8 hold", {15'd0, dout}, {15'd0, dhold});
  endtask

  task automatic set_phase(input logic m);
    phase_sel = m;
    phase_load = 1'b1;
    wait_clk(1);
    phase_load = 1'b0;
    wait_clk(2);
    bmode = m;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] wsave;
    logic dsave;
    void'($urandom(32'h5eed));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    chk(dout === 1'b0, "R1 dout", {15'd0, dout}, 16'd0);
    chk(word === '0, "R1 word", word, 16'd0);
    chk(word_valid === 1'b0, "R1 valid", {15'd0, word_valid}, 16'd0);

    // R4 default phase, directed exact frame
    frame(16, 32'h0000A5C3, "");
    frame(16, 32'h00003C96, "");
    // short frame mixes with history (R2)
    frame(3, 32'h5, "");
    frame(24, 32'h00F0F0F0, "");

    // R6: phase_sel toggled without load has no effect
    phase_sel = 1'b1;
    wait_clk(3);
    phase_sel = 1'b0;
    wait_clk(1);
    phase_sel = 1'b1;
    wait_clk(3);
    frame(18, 32'h0002B3D1, "R6 no load");

    // R5 rising-edge mode
    set_phase(1'b1);
    frame(16, 32'h0000FFFF, "");
    frame(20, 32'h000A5A5A, "");

    // R7 edges while deselected ignored
    wsave = word;
    dsave = dout;
    for (int i = 0; i < 6; i++) begin
      din = i[0];
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
    end
    chk(dout === dsave, "R7 dout", {15'd0, dout}, {15'd0, dsave});
    chk(word === wsave, "R7 word", word, wsave);
    frame(5, 32'h13, "R7 after");

    // back to falling mode, then random frames with random phase loads
    set_phase(1'b0);
    frame(16, 32'h00001234, "");
    for (int f = 0; f < 50; f++) begin
      if ($urandom_range(3) == 0) set_phase(1'($urandom_range(1)));
      frame(int'($urandom_range(24, 1)), $urandom, "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule